// File: doc/BRIEF.md
# Six-Output PWM Drive Stage with Crossover, Carrier Chopping and Trip

This block sits between a three-phase PWM timer and the six gate-drive pins of an inverter. It receives, for each of three phase pairs, a raw high-side request and a raw low-side request (active high: 1 means "switch on"). It produces six active-low pins, where logic high is the OFF level. Each pair can be crossed over so that the high-side request drives the low-side pin and the other way round. Each pin has its own enable. High-frequency chopping for pulse-transformer gate drivers can be switched on separately for the three high-side pins and for the three low-side pins.

The chopping carrier comes from a prescaler. The prescaler reloads from an 8-bit divider value and toggles the carrier each time it reloads. While chopping is on, an active pin is pulsed at the carrier rate. An inactive pin stays OFF.

An active-low trip input forces all six pins OFF through gates alone, with no flip-flop in the path, so it still acts when the clock is lost. A synchronized copy of the trip pin level is available as a status bit.

Top module: `pwm_out_ctrl`

## Requirements
- R1: When `outEnable` bit 2k is 0, `pinHi[k]` is held high (OFF). When bit 2k+1 is 0, `pinLo[k]` is held high.
- R2: With `crossEn[k]`=0, both chop enables 0, both pins of pair k enabled and `tripN`=1, the pins follow the requests inverted: `pinHi[k]` = NOT `rawHi[k]` and `pinLo[k]` = NOT `rawLo[k]`.
- R3: With `crossEn[k]`=1 the requests are swapped before all later stages: `pinHi[k]` follows NOT `rawLo[k]` and `pinLo[k]` follows NOT `rawHi[k]`.
- R4: The carrier is low in reset. It goes high at the first clock edge after reset is released. It then toggles every N+1 clocks, where N is `chopDiv`, which gives a period of 2×(N+1) clocks.
- R5: With `chopHiEn`=1, a high-side pin whose request (after crossover) is active is low only while the carrier is high. The low-side pins are not affected by `chopHiEn`.
- R6: With `chopLoEn`=1, a low-side pin whose request (after crossover) is active is low only while the carrier is high. The high-side pins are not affected by `chopLoEn`.
- R7: A pin whose request (after crossover) is inactive stays high whatever the carrier and chop enables are.
- R8: While `tripN` is 0, all six pins are high. This does not depend on the clock, the reset or any other input.
- R9: `tripStatus` equals the level `tripN` had two clock edges earlier.
- R10: During reset `tripStatus` reads 1, and chopped pins are OFF because the carrier is low.
- R11: A new `chopDiv` value takes effect at the next prescaler reload. The half-period that is running finishes with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rawHi | input | 3 | High-side requests from the timer, active high, one per pair |
| rawLo | input | 3 | Low-side requests from the timer, active high, one per pair |
| outEnable | input | 6 | Per-pin enable: bit 2k is pair k high side, bit 2k+1 is pair k low side |
| crossEn | input | 3 | Per-pair crossover |
| chopDiv | input | 8 | Carrier divider N (half-period N+1 clocks) |
| chopHiEn | input | 1 | Chopping enable for the high-side pins |
| chopLoEn | input | 1 | Chopping enable for the low-side pins |
| tripN | input | 1 | Active-low trip, forces all pins OFF without clocking |
| pinHi | output | 3 | High-side drive pins, active low |
| pinLo | output | 3 | Low-side drive pins, active low |
| tripStatus | output | 1 | Synchronized trip pin level |

## Verification
Directed patterns separate direct routing from crossover by giving the two requests of a pair opposite values, so a swap is visible. They also give each pin its own enable value, which shows that each enable bit reaches the right pin. Measured run lengths of a chopped pin at two divider values, with the value changed in the middle of a half-period, tell the carrier period apart from an off-by-one error and check when a reload picks up a new divider. Random requests, enables, crossovers, chop enables, divider values and short trip pulses are then compared every cycle against a bench model of the carrier. A trip is also applied between clock edges, which shows that the pins react without waiting for a clock.

// File: rtl/pwm_out_pkg.sv
package pwm_out_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic carrier;  // chopping carrier level
    logic reload;   // prescaler reloads at the coming edge
  } chopStrobe_t;
endpackage

// File: rtl/pwm_chop_ctrl.sv
module pwm_chop_ctrl
  import pwm_out_pkg::*;
#(
  parameter int DIV_WIDTH = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DIV_WIDTH-1:0] chopDiv,
  input  logic                 tripN,
  output chopStrobe_t          strobe,
  output logic                 tripStatus
);
  localparam int SYNC_STAGES = 2;

  logic [DIV_WIDTH-1:0]   preCnt;
  logic                   carrierQ;
  logic [SYNC_STAGES-1:0] tripSync;
  logic                   atReload;

  assign atReload = (preCnt == '0);

  // Prescaler: reload from chopDiv and toggle the carrier on each reload
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      carrierQ <= 1'b0;
    end else if (atReload) begin
      preCnt   <= chopDiv;
      carrierQ <= ~carrierQ;
    end else begin
      preCnt   <= preCnt - 1'b1;
    end
  end

  // Trip level synchronizer for the status bit only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tripSync <= '1;
    else       tripSync <= {tripSync[SYNC_STAGES-2:0], tripN};
  end

  assign strobe.carrier = carrierQ;
  assign strobe.reload  = atReload;
  assign tripStatus     = tripSync[SYNC_STAGES-1];

  // R4: the carrier changes only on a reload
  p_carrier_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.reload |=> $stable(strobe.carrier));
  p_carrier_flip_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> (strobe.carrier != $past(strobe.carrier)));
  // R9: two-edge status lag
  p_status_lag_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rstN, 2)) |-> (tripStatus == $past(tripN, 2)));
endmodule

// File: rtl/pwm_out_datapath.sv
module pwm_out_datapath
  import pwm_out_pkg::*;
#(
  parameter int NUM_PAIRS = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_PAIRS-1:0]   rawHi,
  input  logic [NUM_PAIRS-1:0]   rawLo,
  input  logic [2*NUM_PAIRS-1:0] outEnable,
  input  logic [NUM_PAIRS-1:0]   crossEn,
  input  logic                   chopHiEn,
  input  logic                   chopLoEn,
  input  logic                   tripN,
  input  chopStrobe_t            strobe,
  output logic [NUM_PAIRS-1:0]   pinHi,
  output logic [NUM_PAIRS-1:0]   pinLo
);
  logic gateHi, gateLo;

  // Chopping gate per side: pass when chopping is off or the carrier is high
  assign gateHi = ~chopHiEn | strobe.carrier;
  assign gateLo = ~chopLoEn | strobe.carrier;

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    logic selHi, selLo, actHi, actLo;

    // Crossover first
    assign selHi = crossEn[k] ? rawLo[k] : rawHi[k];
    assign selLo = crossEn[k] ? rawHi[k] : rawLo[k];

    // Chopping applies to the active phase only, then the enable
    assign actHi = selHi & gateHi & outEnable[2*k];
    assign actLo = selLo & gateLo & outEnable[2*k+1];

    // Unclocked trip override; pins are active low
    assign pinHi[k] = ~(actHi & tripN);
    assign pinLo[k] = ~(actLo & tripN);

    p_disabled_hi_r1: assert property (@(posedge clk) disable iff (!rstN)
      !outEnable[2*k] |-> pinHi[k]);
    p_disabled_lo_r1: assert property (@(posedge clk) disable iff (!rstN)
      !outEnable[2*k+1] |-> pinLo[k]);
    p_cross_r3: assert property (@(posedge clk) disable iff (!rstN)
      (tripN && crossEn[k] && outEnable[2*k] && !chopHiEn) |-> (pinHi[k] == !rawLo[k]));
    p_idle_off_r7: assert property (@(posedge clk) disable iff (!rstN)
      (!rawHi[k] && !rawLo[k]) |-> (pinHi[k] && pinLo[k]));
  end

  p_trip_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !tripN |-> (&pinHi && &pinLo));
endmodule

// File: rtl/pwm_out_ctrl.sv
module pwm_out_ctrl
  import pwm_out_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  parameter int DIV_WIDTH = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_PAIRS-1:0]   rawHi,
  input  logic [NUM_PAIRS-1:0]   rawLo,
  input  logic [2*NUM_PAIRS-1:0] outEnable,
  input  logic [NUM_PAIRS-1:0]   crossEn,
  input  logic [DIV_WIDTH-1:0]   chopDiv,
  input  logic                   chopHiEn,
  input  logic                   chopLoEn,
  input  logic                   tripN,
  output logic [NUM_PAIRS-1:0]   pinHi,
  output logic [NUM_PAIRS-1:0]   pinLo,
  output logic                   tripStatus
);
  chopStrobe_t strobe;

  pwm_chop_ctrl #(.DIV_WIDTH(DIV_WIDTH)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .chopDiv    (chopDiv),
    .tripN      (tripN),
    .strobe     (strobe),
    .tripStatus (tripStatus)
  );

  pwm_out_datapath #(.NUM_PAIRS(NUM_PAIRS)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .rawHi     (rawHi),
    .rawLo     (rawLo),
    .outEnable (outEnable),
    .crossEn   (crossEn),
    .chopHiEn  (chopHiEn),
    .chopLoEn  (chopLoEn),
    .tripN     (tripN),
    .strobe    (strobe),
    .pinHi     (pinHi),
    .pinLo     (pinLo)
  );
endmodule

// File: tb/pwm_out_ctrl_tb.sv
module pwm_out_ctrl_tb_top;
  localparam int P = 3;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [P-1:0]   rawHi = '0, rawLo = '0, crossEn = '0;
  logic [2*P-1:0] outEnable = '0;
  logic [W-1:0]   chopDiv = '0;
  logic chopHiEn = 1'b0, chopLoEn = 1'b0, tripN = 1'b1;
  logic [P-1:0] pinHi, pinLo;
  logic tripStatus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_out_ctrl #(.NUM_PAIRS(P), .DIV_WIDTH(W)) dut_i (
    .clk(clk), .rstN(rstN), .rawHi(rawHi), .rawLo(rawLo), .outEnable(outEnable),
    .crossEn(crossEn), .chopDiv(chopDiv), .chopHiEn(chopHiEn), .chopLoEn(chopLoEn),
    .tripN(tripN), .pinHi(pinHi), .pinLo(pinLo), .tripStatus(tripStatus)
  );

  // Requirement models: carrier per R4/R11, status lag per R9/R10
  logic [W-1:0] mCnt;
  logic mCar;
  logic [1:0] mSync;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt <= '0; mCar <= 1'b0; mSync <= 2'b11;
    end else begin
      if (mCnt == 0) begin mCnt <= chopDiv; mCar <= ~mCar; end
      else mCnt <= mCnt - 1'b1;
      mSync <= {mSync[0], tripN};
    end
  end

  function automatic logic expPin(bit hiSide, int k);
    logic req, en, chop;
    req  = hiSide ? (crossEn[k] ? rawLo[k] : rawHi[k]) : (crossEn[k] ? rawHi[k] : rawLo[k]);
    en   = hiSide ? outEnable[2*k] : outEnable[2*k+1];
    chop = hiSide ? chopHiEn : chopLoEn;
    return !(tripN && req && en && (!chop || mCar));
  endfunction

  task automatic checkBit(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    for (int k = 0; k < P; k++) begin
      for (int s = 0; s < 2; s++) begin
        string lbl;
        logic req, en, chop;
        req  = (s == 1) ? (crossEn[k] ? rawLo[k] : rawHi[k]) : (crossEn[k] ? rawHi[k] : rawLo[k]);
        en   = (s == 1) ? outEnable[2*k] : outEnable[2*k+1];
        chop = (s == 1) ? chopHiEn : chopLoEn;
        if (!tripN) lbl = "R8";
        else if (!en) lbl = "R1";
        else if (!req) lbl = "R7";
        else if (chop) lbl = (s == 1) ? "R5" : "R6";
        else if (crossEn[k]) lbl = "R3";
        else lbl = "R2";
        checkBit(lbl, (s == 1) ? pinHi[k] : pinLo[k], expPin(s == 1, k),
                 $sformatf("pair %0d %s", k, (s == 1) ? "hi" : "lo"));
      end
    end
    checkBit(rstN ? "R9" : "R10", tripStatus, mSync[1], "tripStatus");
  endtask

  // Length of the next run of pinHi[0] at its current level
  task automatic runLen(output int n);
    logic lvl;
    lvl = pinHi[0];
    n = 0;
    while (pinHi[0] == lvl && n < 600) begin
      n++;
      @(negedge clk); #1;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    // R10: reset state, chopped active pins stay OFF while the carrier is low
    rawHi = '1; rawLo = '1; outEnable = '1; chopHiEn = 1'b1; chopLoEn = 1'b1; chopDiv = 8'd2;
    repeat (3) @(negedge clk);
    #1;
    checkBit("R10", &pinHi && &pinLo, 1'b1, "pins in reset");
    checkBit("R10", tripStatus, 1'b1, "status in reset");
    @(negedge clk); rstN = 1'b1;

    // R2: direct routing with distinct requests
    chopHiEn = 1'b0; chopLoEn = 1'b0;
    rawHi = 3'b101; rawLo = 3'b010; crossEn = '0;
    #1; checkAll();
    // R3: crossover on pairs 0 and 2 only
    @(negedge clk); crossEn = 3'b101; #1; checkAll();
    // R1: individual enables
    @(negedge clk); crossEn = '0; rawHi = '1; rawLo = '1; outEnable = 6'b011010; #1; checkAll();
    checkBit("R1", pinHi[0], 1'b1, "pair0 hi disabled");
    checkBit("R1", pinLo[1], 1'b0, "pair1 lo enabled");
    // R8: trip between edges, no clock needed
    @(negedge clk); outEnable = '1; #1;
    #1 tripN = 1'b0; #1;
    checkBit("R8", &pinHi && &pinLo, 1'b1, "pins during trip");
    @(negedge clk); #1; checkAll();
    @(negedge clk); #1; checkAll();
    checkBit("R9", tripStatus, 1'b0, "status after trip");
    @(negedge clk); tripN = 1'b1; #1; checkAll();

    // R4: carrier period with N=3 on a chopped high-side pin
    rawHi = '1; rawLo = '0; outEnable = '1; chopHiEn = 1'b1; chopDiv = 8'd3;
    runLen(n); runLen(n); runLen(n);
    checkBit("R4", n == 4, 1'b1, $sformatf("half-period %0d", n));
    runLen(n);
    checkBit("R4", n == 4, 1'b1, $sformatf("half-period %0d", n));
    // R11: change mid half-period, next full run uses the new value
    @(negedge clk); chopDiv = 8'd6; #1;
    runLen(n); runLen(n);
    checkBit("R11", n == 7, 1'b1, $sformatf("half-period %0d", n));
    // R5: low side untouched by the high-side enable
    rawLo = '1; rawHi = '0; #1;
    for (int i = 0; i < 16; i++) begin
      checkBit("R5", &pinLo, 1'b0, "low side not chopped");
      @(negedge clk); #1;
    end
    chopHiEn = 1'b0;

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      rawHi = 3'($urandom); rawLo = 3'($urandom);
      if ($urandom_range(7) == 0) begin
        outEnable = 6'($urandom) | 6'($urandom);
        crossEn = 3'($urandom);
        chopHiEn = 1'($urandom); chopLoEn = 1'($urandom);
      end
      if ($urandom_range(63) == 0) chopDiv = 8'($urandom_range(7));
      tripN = ($urandom_range(15) != 0);
      #1; checkAll();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule